// File: doc/BRIEF.md
# Register Rename Table with Free Tag Pool

This block translates architectural register numbers into physical register tags for a single instruction per cycle. For each renamed instruction it returns the physical tags of both source operands, a newly allocated physical tag for the destination, and the tag that the destination used to map to. The caller keeps that displaced tag with the in-flight instruction so that it can hand the tag back when the instruction retires.

Two copies of the mapping are kept. A speculative map changes at rename. A committed map changes only when an instruction retires. Unused physical tags live in a pool. At rename a tag leaves the pool. A tag goes back into the pool only when the instruction that displaced it retires. On a flush, the speculative map is overwritten with the committed map, and the pool is rebuilt as every tag the committed map does not reference. Tags held by discarded in-flight instructions are recovered this way.

The default configuration has 8 architectural and 32 physical registers. Architectural register 0 is fixed to physical tag 0.

Top module: `rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i, and physical tags 8 to 31 are in the pool.
- R2: An accepted rename whose destination is a non-zero architectural register receives the lowest-numbered pooled tag. That tag leaves the pool, and the speculative map entry of the destination becomes that tag.
- R3: Both source tags are read from the map as it stood before the instruction's own destination update, so a source equal to the destination returns the old tag.
- R4: `ren_old_tag` shows the tag the destination mapped to before the rename. `ren_new_tag` and `ren_old_tag` both read 0 when the instruction allocates nothing.
- R5: A displaced tag re-enters the pool only on the cycle a retirement reports it on `ret_old_tag`, and it is available for allocation from the next cycle on.
- R6: When the pool is empty, `ren_ready` is low for an instruction that needs a destination. An instruction with `ren_has_dst` low is always ready outside a flush and allocates nothing.
- R7: A flush copies the committed map into the speculative map, and it rebuilds the pool as every non-zero tag that the committed map does not reference. A retirement in the same cycle is included.
- R8: A retirement with a non-zero destination writes `ret_new_tag` into the committed map entry of `ret_dst`.
- R9: Architectural register 0 always reads tag 0, is never renamed and never allocates, even when `ren_has_dst` is high.
- R10: During a flush cycle `ren_ready` is low, and a rename presented in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard speculative state and restore from the committed map |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Instruction writes a destination register |
| ren_dst | input | 3 | Architectural destination |
| ren_src0 | input | 3 | Architectural source 0 |
| ren_src1 | input | 3 | Architectural source 1 |
| ren_ready | output | 1 | Rename is accepted this cycle if valid |
| ren_src0_tag | output | 5 | Physical tag of source 0 |
| ren_src1_tag | output | 5 | Physical tag of source 1 |
| ren_new_tag | output | 5 | Tag allocated to the destination |
| ren_old_tag | output | 5 | Tag the destination mapped to before this rename |
| ret_valid | input | 1 | Retirement present |
| ret_has_dst | input | 1 | Retiring instruction wrote a destination |
| ret_dst | input | 3 | Architectural destination of the retiring instruction |
| ret_new_tag | input | 5 | Tag the retiring instruction was allocated |
| ret_old_tag | input | 5 | Tag the retiring instruction displaced |

## Verification
A corrupted speculative entry appears on the source tag outputs on the first read of that register, in the same cycle. The bench therefore reads every pair of sources after reset and after each flush. A pool that leaks or duplicates tags appears as a wrong allocation order, or as `ren_ready` dropping at the wrong moment when the pool runs dry. The bench renames until the pool is exhausted and compares every allocated tag with a lowest-free model. A committed map error stays hidden until the next flush, and then shows at once on the source tags and on the first allocations afterwards.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
    parameter int unsigned ARCH_REGS = 8;
    parameter int unsigned PHYS_REGS = 32;
    localparam int unsigned ARCH_W = $clog2(ARCH_REGS);
    localparam int unsigned TAG_W  = $clog2(PHYS_REGS);

    typedef logic [ARCH_W-1:0] arch_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [ARCH_REGS-1:0][TAG_W-1:0] map_t;
    typedef logic [PHYS_REGS-1:0] pool_t;

    // Architectural register 0 is hard-wired and never takes a tag.
    function automatic logic writes_dst(input logic has_dst, input arch_t dst);
        return has_dst && (dst != '0);
    endfunction
endpackage

// File: rtl/rt_free_list.sv
`timescale 1ns/1ps
module rt_free_list
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  logic  release_en,
    input  tag_t  release_tag,
    input  logic  rebuild,
    input  pool_t in_use,
    output logic  has_free,
    output tag_t  pick
);
    localparam pool_t RESET_POOL = {PHYS_REGS{1'b1}} << ARCH_REGS;
    localparam pool_t ZERO_BIT   = pool_t'(1);

    pool_t free_q;
    pool_t take_mask;
    pool_t give_mask;

    // Lowest-numbered free tag wins; tag 0 is never considered.
    always_comb begin
        pick = '0;
        for (int i = PHYS_REGS - 1; i >= 1; i--) begin
            if (free_q[i]) pick = tag_t'(i);
        end
        has_free = |free_q;
    end

    always_comb begin
        take_mask = alloc      ? (ZERO_BIT << pick)        : '0;
        give_mask = release_en ? (ZERO_BIT << release_tag) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= RESET_POOL;
        end else if (rebuild) begin
            free_q <= ~in_use & ~ZERO_BIT;
        end else begin
            free_q <= (free_q & ~take_mask) | give_mask;
        end
    end

    p_alloc_removes_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc && !rebuild) |=> !free_q[$past(pick)]);

    p_release_returns_r5: assert property (@(posedge clk) disable iff (rst)
        release_en |=> free_q[$past(release_tag)]);

    p_zero_never_pooled_r9: assert property (@(posedge clk) disable iff (rst)
        !free_q[0]);
endmodule

// File: rtl/rt_map_table.sv
`timescale 1ns/1ps
module rt_map_table
    import rt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  arch_t rd0,
    input  arch_t rd1,
    input  arch_t rd_dst,
    output tag_t  rd_tag0,
    output tag_t  rd_tag1,
    output tag_t  rd_old,
    input  logic  wr_en,
    input  arch_t wr_dst,
    input  tag_t  wr_tag,
    input  logic  cm_en,
    input  arch_t cm_dst,
    input  tag_t  cm_tag,
    input  logic  restore,
    output pool_t cm_in_use
);
    map_t spec_q;
    map_t cm_q;
    map_t cm_next;

    // Reads see the map before this cycle's write.
    always_comb begin
        rd_tag0 = (rd0 == '0) ? '0 : spec_q[rd0];
        rd_tag1 = (rd1 == '0) ? '0 : spec_q[rd1];
        rd_old  = spec_q[rd_dst];
    end

    always_comb begin
        cm_next = cm_q;
        if (cm_en) cm_next[cm_dst] = cm_tag;
    end

    always_comb begin
        cm_in_use = '0;
        for (int a = 0; a < ARCH_REGS; a++) begin
            cm_in_use[cm_next[a]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                spec_q[a] <= tag_t'(a);
                cm_q[a]   <= tag_t'(a);
            end
        end else begin
            cm_q <= cm_next;
            if (restore) begin
                spec_q <= cm_next;
            end else if (wr_en) begin
                spec_q[wr_dst] <= wr_tag;
            end
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !restore) |=> spec_q[$past(wr_dst)] == $past(wr_tag));

    p_restore_matches_r7: assert property (@(posedge clk) disable iff (rst)
        restore |=> spec_q == cm_q);

    p_commit_lands_r8: assert property (@(posedge clk) disable iff (rst)
        cm_en |=> cm_q[$past(cm_dst)] == $past(cm_tag));

    p_arch0_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        (spec_q[0] == '0) && (cm_q[0] == '0));
endmodule

// File: rtl/rename_table.sv
`timescale 1ns/1ps
module rename_table
    import rt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    ren_valid,
    input  logic                    ren_has_dst,
    input  logic [rt_pkg::ARCH_W-1:0] ren_dst,
    input  logic [rt_pkg::ARCH_W-1:0] ren_src0,
    input  logic [rt_pkg::ARCH_W-1:0] ren_src1,
    output logic                    ren_ready,
    output logic [rt_pkg::TAG_W-1:0]  ren_src0_tag,
    output logic [rt_pkg::TAG_W-1:0]  ren_src1_tag,
    output logic [rt_pkg::TAG_W-1:0]  ren_new_tag,
    output logic [rt_pkg::TAG_W-1:0]  ren_old_tag,
    input  logic                    ret_valid,
    input  logic                    ret_has_dst,
    input  logic [rt_pkg::ARCH_W-1:0] ret_dst,
    input  logic [rt_pkg::TAG_W-1:0]  ret_new_tag,
    input  logic [rt_pkg::TAG_W-1:0]  ret_old_tag
);
    logic  needs_tag;
    logic  fire;
    logic  do_alloc;
    logic  do_retire;
    logic  has_free;
    tag_t  pick;
    tag_t  map_old;
    pool_t cm_in_use;

    always_comb begin
        needs_tag   = writes_dst(ren_has_dst, ren_dst);
        ren_ready   = !flush && (!needs_tag || has_free);
        fire        = ren_valid && ren_ready;
        do_alloc    = fire && needs_tag;
        do_retire   = ret_valid && writes_dst(ret_has_dst, ret_dst);
        ren_new_tag = needs_tag ? pick    : '0;
        ren_old_tag = needs_tag ? map_old : '0;
    end

    rt_map_table i_map (
        .clk       (clk),
        .rst       (rst),
        .rd0       (ren_src0),
        .rd1       (ren_src1),
        .rd_dst    (ren_dst),
        .rd_tag0   (ren_src0_tag),
        .rd_tag1   (ren_src1_tag),
        .rd_old    (map_old),
        .wr_en     (do_alloc),
        .wr_dst    (ren_dst),
        .wr_tag    (pick),
        .cm_en     (do_retire),
        .cm_dst    (ret_dst),
        .cm_tag    (ret_new_tag),
        .restore   (flush),
        .cm_in_use (cm_in_use)
    );

    rt_free_list i_pool (
        .clk         (clk),
        .rst         (rst),
        .alloc       (do_alloc),
        .release_en  (do_retire),
        .release_tag (ret_old_tag),
        .rebuild     (flush),
        .in_use      (cm_in_use),
        .has_free    (has_free),
        .pick        (pick)
    );

    p_stall_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && needs_tag && !has_free) |-> !ren_ready);

    p_src_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (ren_src0 == '0) |-> (ren_src0_tag == '0));

    p_new_not_old_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && needs_tag) |-> (ren_new_tag != ren_old_tag));
endmodule

// File: tb/test_rename_table.sv
`timescale 1ns/1ps
module test_rename_table;
    logic       clk = 1'b0;
    logic       rst;
    logic       flush;
    logic       ren_valid, ren_has_dst;
    logic [2:0] ren_dst, ren_src0, ren_src1;
    logic       ren_ready;
    logic [4:0] ren_src0_tag, ren_src1_tag, ren_new_tag, ren_old_tag;
    logic       ret_valid, ret_has_dst;
    logic [2:0] ret_dst;
    logic [4:0] ret_new_tag, ret_old_tag;

    always #10 clk = ~clk;

    rename_table i_rename_table (
        .clk(clk), .rst(rst), .flush(flush),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_ready(ren_ready),
        .ren_src0_tag(ren_src0_tag), .ren_src1_tag(ren_src1_tag),
        .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
        .ret_valid(ret_valid), .ret_has_dst(ret_has_dst), .ret_dst(ret_dst),
        .ret_new_tag(ret_new_tag), .ret_old_tag(ret_old_tag)
    );

    int n_chk = 0;
    int n_err = 0;
    int m_spec[8];
    int m_cm[8];
    bit m_free[32];
    int q_dst[64];
    int q_new[64];
    int q_old[64];
    int q_head = 0;
    int q_tail = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 1; i < 32; i++) if (m_free[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 8; a++) begin m_spec[a] = a; m_cm[a] = a; end
        for (int t = 0; t < 32; t++) m_free[t] = (t >= 8);
        q_head = 0; q_tail = 0;
    endtask

    task automatic cycle(input bit fl, input bit v, input bit hd, input int d,
                         input int s0, input int s1, input bit rv, input int rd,
                         input int rn, input int ro, input string req);
        bit needs, any, exp_rdy, acc;
        int exp_new;
        @(negedge clk);
        flush = fl; ren_valid = v; ren_has_dst = hd; ren_dst = 3'(d);
        ren_src0 = 3'(s0); ren_src1 = 3'(s1);
        ret_valid = rv; ret_has_dst = rv; ret_dst = 3'(rd);
        ret_new_tag = 5'(rn); ret_old_tag = 5'(ro);
        #1;
        needs = hd && (d != 0);
        any = 1'b0;
        for (int t = 1; t < 32; t++) if (m_free[t]) any = 1'b1;
        exp_rdy = !fl && (!needs || any);
        exp_new = lowest_free();
        check(req, "src0 tag", int'(ren_src0_tag), m_spec[s0]);
        check(req, "src1 tag", int'(ren_src1_tag), m_spec[s1]);
        if (v) begin
            check(req, "ready", int'(ren_ready), int'(exp_rdy));
            if (exp_rdy) begin
                check(req, "new tag", int'(ren_new_tag), needs ? exp_new : 0);
                check(req, "old tag", int'(ren_old_tag), needs ? m_spec[d] : 0);
            end
        end
        acc = v && exp_rdy && needs;
        @(posedge clk);
        if (rv && rd != 0) begin
            m_cm[rd] = rn;
            m_free[ro] = 1'b1;
        end
        if (acc) begin
            m_free[exp_new] = 1'b0;
            q_dst[q_tail % 64] = d; q_new[q_tail % 64] = exp_new; q_old[q_tail % 64] = m_spec[d];
            q_tail++;
            m_spec[d] = exp_new;
        end
        if (fl) begin
            for (int t = 0; t < 32; t++) m_free[t] = (t != 0);
            for (int a = 0; a < 8; a++) begin m_spec[a] = m_cm[a]; m_free[m_cm[a]] = 1'b0; end
            q_head = 0; q_tail = 0;
        end
    endtask

    task automatic ren(input int s0, input int s1, input bit hd, input int d, input string req);
        cycle(1'b0, 1'b1, hd, d, s0, s1, 1'b0, 0, 0, 0, req);
    endtask

    // Retire the oldest in-flight rename, optionally renaming in the same cycle.
    task automatic retire_with(input bit fl, input bit v, input int d, input string req);
        int h;
        if (q_tail == q_head) begin
            cycle(fl, v, 1'b1, d, 1, 2, 1'b0, 0, 0, 0, req);
        end else begin
            h = q_head % 64;
            q_head++;
            cycle(fl, v, 1'b1, d, 1, 2, 1'b1, q_dst[h], q_new[h], q_old[h], req);
        end
    endtask

    task automatic read_sweep(input string req);
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                cycle(1'b0, 1'b0, 1'b0, 0, a, b, 1'b0, 0, 0, 0, req);
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; ren_valid = 1'b0; ren_has_dst = 1'b0;
        ren_dst = '0; ren_src0 = '0; ren_src1 = '0;
        ret_valid = 1'b0; ret_has_dst = 1'b0; ret_dst = '0;
        ret_new_tag = '0; ret_old_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_reset();

        read_sweep("R1");                      // identity map after reset
        ren(0, 0, 1'b1, 1, "R1");              // first allocation is tag 8
        ren(2, 3, 1'b1, 2, "R2");
        ren(1, 5, 1'b1, 1, "R2");              // reads the freshly allocated r1
        ren(1, 1, 1'b1, 1, "R3");              // source equals destination
        ren(4, 5, 1'b1, 4, "R4");
        ren(3, 6, 1'b0, 3, "R4");              // no destination: tags read 0
        ren(0, 7, 1'b1, 0, "R9");              // arch 0 never allocates
        retire_with(1'b0, 1'b0, 0, "R8");
        retire_with(1'b0, 1'b0, 0, "R5");

        for (int k = 0; k < 40; k++)
            ren(k % 8, (k + 3) % 8, 1'b1, (k % 7) + 1, "R6");
        ren(2, 4, 1'b0, 5, "R6");              // pool empty, no destination
        ren(0, 6, 1'b1, 0, "R9");              // pool empty, arch 0 destination
        ren(1, 2, 1'b1, 3, "R6");              // still stalled

        retire_with(1'b0, 1'b0, 0, "R5");
        ren(5, 6, 1'b1, 6, "R5");              // gets the tag just returned
        for (int k = 0; k < 4; k++) retire_with(1'b0, 1'b1, (k % 7) + 1, "R5");

        retire_with(1'b1, 1'b1, 2, "R10");     // flush with retire and rename
        read_sweep("R7");
        for (int k = 0; k < 12; k++) ren(k % 8, 7 - (k % 8), 1'b1, (k % 7) + 1, "R7");
        for (int k = 0; k < 5; k++) retire_with(1'b0, 1'b0, 0, "R8");
        cycle(1'b1, 1'b0, 1'b0, 0, 0, 0, 1'b0, 0, 0, 0, "R7");
        read_sweep("R7");
        for (int k = 0; k < 30; k++) ren((k + 1) % 8, k % 8, 1'b1, (k % 7) + 1, "R2");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule